// File: doc/BRIEF.md
# Configuration Write Guard

This block owns a small bank of memory-mapped configuration registers and decides, for each bus write, whether that write may land. The registers fall into three groups: a mutable section (`0x800 + 4*i`), which is closed by default and opened for a short time by a 32-bit key; an immutable section (`0x400 + 4*i`), which can be written freely until a global lock is set; and key-guarded registers (`0x100 + 4*k`), which take a write only when the top byte of the write data carries a one-byte key.

A global lock, once set, blocks all three groups until reset. A status word shows the lock state. The bus is a plain single-cycle interface: address, write strobe, write data, and read data that follows the address combinationally. A write takes effect at the rising clock edge where `bus_we` is high.

Top module: `cfg_write_guard`

## Requirements
- R1: Address `0x010` reads the status word. Bits 31 and 30 always read 1. Bit 1 is 1 while the mutable section is open. Bit 0 is 1 while the global lock is set. All other bits read 0. After reset the word is `0xC000_0000`.
- R2: A write of exactly `0xC5AF_6927` to `0x00C` opens the mutable section from the next cycle. The same write while the section is already open keeps it open.
- R3: A write of any other value to `0x00C` closes the mutable section from the next cycle.
- R4: The mutable section closes by itself after 32 consecutive clock edges with no write to a mutable-section address. Any write to a mutable address, whether accepted or rejected, restarts that count.
- R5: A write to a mutable register changes it only while the section is open and the global lock is clear. Otherwise its contents stay unchanged.
- R6: A write to `0x008` with bit 0 set sets the global lock. A write with bit 0 clear has no effect. Only reset clears the lock.
- R7: While the global lock is set, writes to mutable, immutable and key-guarded registers are all rejected, even when the mutable section is open.
- R8: A key-guarded register accepts a write only when write data bits 31:24 equal `0x5A` and the global lock is clear. Otherwise the whole write is ignored. Bits 31:24 of these registers always read `0x00`.
- R9: The lock addresses `0x008` and `0x00C`, and every unmapped address, read as 0.
- R10: Immutable registers accept writes whenever the global lock is clear, with no unlock needed.
- R11: Reset clears every stored register to 0, closes the mutable section and clears the global lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| glock_o | output | 1 | Global lock state |
| mopen_o | output | 1 | Mutable section open |

## Verification
A wrong lock state shows up on `mopen_o`, `glock_o` and the status word on the first edge after the write that caused it. The check can therefore read the status right after each key write. An idle counter that drifts by one moves the self-close by one cycle, so the open flag is sampled both after the 31st idle edge and after the 32nd. A write gate that misjudges a write leaves the wrong value in a register, and that value is visible on the very next read of that address.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_GLOCK  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_UNLOCK = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h010;

    localparam logic [3:0] PAGE_KEYED = 4'h1;
    localparam logic [3:0] PAGE_IMM   = 4'h4;
    localparam logic [3:0] PAGE_MUT   = 4'h8;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hC5AF_6927;
    localparam logic [7:0]        WRITE_KEY  = 8'h5A;
    localparam logic [1:0]        STATUS_HI  = 2'b11;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_MUT,
        SEL_IMM,
        SEL_KEYED
    } rd_sel_e;
endpackage

// File: rtl/cwg_lock_ctrl.sv
module cwg_lock_ctrl
    import cwg_pkg::*;
#(
    parameter int IDLE_CYCLES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              hit_glock,
    input  logic              hit_unlock,
    input  logic              hit_mut,
    input  logic [DATA_W-1:0] wdata,
    output logic              glock,
    output logic              mopen
);
    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_CYCLES - 1);

    typedef struct packed {
        logic             glock;
        logic             open;
        logic [CNT_W-1:0] idle;
    } lock_state_t;

    lock_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we && hit_glock && wdata[0]) begin
            s_d.glock = 1'b1;
        end
        if (we && hit_unlock) begin
            s_d.open = (wdata == UNLOCK_KEY);
            s_d.idle = '0;
        end else if (s_q.open) begin
            if (we && hit_mut) begin
                s_d.idle = '0;
            end else if (s_q.idle == CNT_LAST) begin
                s_d.open = 1'b0;
                s_d.idle = '0;
            end else begin
                s_d.idle = s_q.idle + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign glock = s_q.glock;
    assign mopen = s_q.open;

    assert_glock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.glock |=> s_q.glock);
    assert_goodkey_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_unlock && wdata == UNLOCK_KEY) |=> s_q.open);
    assert_badkey_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_unlock && wdata != UNLOCK_KEY) |=> !s_q.open);
    assert_idle_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.open |-> (s_q.idle <= CNT_LAST));
    assert_idle_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.open |-> (s_q.idle == '0));
endmodule

// File: rtl/cwg_write_gate.sv
module cwg_write_gate
    import cwg_pkg::*;
#(
    parameter int N_MUT = 4,
    parameter int N_IMM = 4,
    parameter int N_KEY = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [7:0]        key_byte,
    input  logic              glock,
    input  logic              mopen,
    output logic              hit_glock,
    output logic              hit_unlock,
    output logic              hit_mut,
    output rd_sel_e           rd_sel,
    output logic [5:0]        idx,
    output logic [N_MUT-1:0]  wen_mut,
    output logic [N_IMM-1:0]  wen_imm,
    output logic [N_KEY-1:0]  wen_key
);
    logic [3:0] page;
    logic       aligned;
    logic       in_mut, in_imm, in_key, in_stat;
    logic       ok_mut, ok_imm, ok_key;

    always_comb begin
        page       = addr[11:8];
        idx        = addr[7:2];
        aligned    = (addr[1:0] == 2'b00);
        in_mut     = aligned && (page == PAGE_MUT)   && (int'(idx) < N_MUT);
        in_imm     = aligned && (page == PAGE_IMM)   && (int'(idx) < N_IMM);
        in_key     = aligned && (page == PAGE_KEYED) && (int'(idx) < N_KEY);
        in_stat    = (addr == OFS_STATUS);
        hit_glock  = (addr == OFS_GLOCK);
        hit_unlock = (addr == OFS_UNLOCK);
        hit_mut    = in_mut;

        if (in_stat)     rd_sel = SEL_STATUS;
        else if (in_mut) rd_sel = SEL_MUT;
        else if (in_imm) rd_sel = SEL_IMM;
        else if (in_key) rd_sel = SEL_KEYED;
        else             rd_sel = SEL_NONE;

        ok_mut = we && in_mut && mopen && !glock;
        ok_imm = we && in_imm && !glock;
        ok_key = we && in_key && !glock && (key_byte == WRITE_KEY);
    end

    for (genvar i = 0; i < N_MUT; i++) begin : g_mut
        assign wen_mut[i] = ok_mut && (idx == 6'(i));
    end
    for (genvar i = 0; i < N_IMM; i++) begin : g_imm
        assign wen_imm[i] = ok_imm && (idx == 6'(i));
    end
    for (genvar i = 0; i < N_KEY; i++) begin : g_key
        assign wen_key[i] = ok_key && (idx == 6'(i));
    end
endmodule

// File: rtl/cwg_reg_bank.sv
module cwg_reg_bank #(
    parameter int N = 4,
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] wen,
    input  logic [W-1:0] wdata,
    input  logic [5:0]   rd_idx,
    output logic [W-1:0] rdata
);
    logic [N-1:0][W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (wen[i]) mem_d[i] = wdata;
            if (rd_idx == 6'(i)) rdata = mem_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assert_no_write_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wen == '0) |=> $stable(mem_q));
    assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wen));
endmodule

// File: rtl/cfg_write_guard.sv
module cfg_write_guard
    import cwg_pkg::*;
#(
    parameter int N_MUT       = 4,
    parameter int N_IMM       = 4,
    parameter int N_KEY       = 2,
    parameter int IDLE_CYCLES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              glock_o,
    output logic              mopen_o
);
    logic             glock, mopen;
    logic             hit_glock, hit_unlock, hit_mut;
    rd_sel_e          rd_sel;
    logic [5:0]       idx;
    logic [N_MUT-1:0] wen_mut;
    logic [N_IMM-1:0] wen_imm;
    logic [N_KEY-1:0] wen_key;
    logic [DATA_W-1:0] mut_rdata, imm_rdata, key_rdata;
    logic [DATA_W-1:0] key_wdata;

    cwg_lock_ctrl #(.IDLE_CYCLES(IDLE_CYCLES)) u_lock (
        .clk(clk), .rst_n(rst_n), .we(bus_we),
        .hit_glock(hit_glock), .hit_unlock(hit_unlock), .hit_mut(hit_mut),
        .wdata(bus_wdata), .glock(glock), .mopen(mopen)
    );

    cwg_write_gate #(.N_MUT(N_MUT), .N_IMM(N_IMM), .N_KEY(N_KEY)) u_gate (
        .addr(bus_addr), .we(bus_we), .key_byte(bus_wdata[31:24]),
        .glock(glock), .mopen(mopen),
        .hit_glock(hit_glock), .hit_unlock(hit_unlock), .hit_mut(hit_mut),
        .rd_sel(rd_sel), .idx(idx),
        .wen_mut(wen_mut), .wen_imm(wen_imm), .wen_key(wen_key)
    );

    assign key_wdata = {8'h00, bus_wdata[23:0]};

    cwg_reg_bank #(.N(N_MUT), .W(DATA_W)) u_mut (
        .clk(clk), .rst_n(rst_n), .wen(wen_mut), .wdata(bus_wdata),
        .rd_idx(idx), .rdata(mut_rdata)
    );
    cwg_reg_bank #(.N(N_IMM), .W(DATA_W)) u_imm (
        .clk(clk), .rst_n(rst_n), .wen(wen_imm), .wdata(bus_wdata),
        .rd_idx(idx), .rdata(imm_rdata)
    );
    cwg_reg_bank #(.N(N_KEY), .W(DATA_W)) u_key (
        .clk(clk), .rst_n(rst_n), .wen(wen_key), .wdata(key_wdata),
        .rd_idx(idx), .rdata(key_rdata)
    );

    always_comb begin
        case (rd_sel)
            SEL_STATUS: bus_rdata = {STATUS_HI, 28'b0, mopen, glock};
            SEL_MUT:    bus_rdata = mut_rdata;
            SEL_IMM:    bus_rdata = imm_rdata;
            SEL_KEYED:  bus_rdata = key_rdata;
            default:    bus_rdata = '0;
        endcase
    end

    assign glock_o = glock;
    assign mopen_o = mopen;

    assert_glock_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        glock |-> (wen_mut == '0 && wen_imm == '0 && wen_key == '0));
    assert_closed_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mopen |-> (wen_mut == '0));
    assert_badkey_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wdata[31:24] != WRITE_KEY) |-> (wen_key == '0));
endmodule

// File: tb/cfg_write_guard_tb.sv
module cfg_write_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        glock_o, mopen_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cfg_write_guard u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .glock_o(glock_o), .mopen_o(mopen_o)
    );

    // entry: {we, addr, wdata, expected read, requirement}
    localparam int NVEC = 25;
    localparam logic [80:0] VEC [NVEC] = '{
        {1'b0, 12'h010, 32'h0, 32'hC000_0000, 4'd1},   // R1 reset status
        {1'b0, 12'h800, 32'h0, 32'h0000_0000, 4'd11},  // R11 reset contents
        {1'b1, 12'h800, 32'h0000_1234, 32'h0, 4'd5},
        {1'b0, 12'h800, 32'h0, 32'h0000_0000, 4'd5},   // R5 closed rejects
        {1'b1, 12'h00C, 32'hC5AF_6927, 32'h0, 4'd2},
        {1'b0, 12'h010, 32'h0, 32'hC000_0002, 4'd2},   // R2 open
        {1'b1, 12'h800, 32'hDEAD_BEEF, 32'h0, 4'd5},
        {1'b0, 12'h800, 32'h0, 32'hDEAD_BEEF, 4'd5},   // R5 open accepts
        {1'b1, 12'h00C, 32'h0000_0001, 32'h0, 4'd3},
        {1'b0, 12'h010, 32'h0, 32'hC000_0000, 4'd3},   // R3 wrong key closes
        {1'b1, 12'h804, 32'h0000_0005, 32'h0, 4'd5},
        {1'b0, 12'h804, 32'h0, 32'h0000_0000, 4'd5},
        {1'b1, 12'h400, 32'hA5A5_A5A5, 32'h0, 4'd10},
        {1'b0, 12'h400, 32'h0, 32'hA5A5_A5A5, 4'd10},  // R10 immutable free
        {1'b1, 12'h100, 32'h1100_00FF, 32'h0, 4'd8},
        {1'b0, 12'h100, 32'h0, 32'h0000_0000, 4'd8},   // R8 bad key ignored
        {1'b1, 12'h100, 32'h5A00_00FF, 32'h0, 4'd8},
        {1'b0, 12'h100, 32'h0, 32'h0000_00FF, 4'd8},   // R8 key byte reads 0
        {1'b1, 12'h104, 32'h5A12_3456, 32'h0, 4'd8},
        {1'b0, 12'h104, 32'h0, 32'h0012_3456, 4'd8},
        {1'b0, 12'h008, 32'h0, 32'h0000_0000, 4'd9},   // R9 lock regs read 0
        {1'b0, 12'h00C, 32'h0, 32'h0000_0000, 4'd9},
        {1'b0, 12'h7FC, 32'h0, 32'h0000_0000, 4'd9},   // R9 unmapped
        {1'b1, 12'h008, 32'h0000_0000, 32'h0, 4'd6},
        {1'b0, 12'h010, 32'h0, 32'hC000_0000, 4'd6}    // R6 zero write no effect
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a; bus_we = 1'b0;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][80]) begin
                wr(VEC[i][79:68], VEC[i][67:36]);
            end else begin
                rd_check($sformatf("R%0d table %0d", VEC[i][3:0], i),
                         VEC[i][79:68], VEC[i][35:4]);
            end
        end

        // R4 self-close after 32 idle edges
        wr(12'h00C, 32'hC5AF_6927);
        repeat (31) @(negedge clk);
        check("R4 open after 31 idle", {31'b0, mopen_o}, 32'd1);
        @(negedge clk);
        check("R4 closed after 32 idle", {31'b0, mopen_o}, 32'd0);

        // R4 mutable write restarts the count
        wr(12'h00C, 32'hC5AF_6927);
        repeat (20) @(negedge clk);
        wr(12'h80C, 32'h0000_0007);
        repeat (31) @(negedge clk);
        check("R4 open after restart", {31'b0, mopen_o}, 32'd1);
        rd_check("R5 write while open", 12'h80C, 32'h0000_0007);
        @(negedge clk);
        check("R4 closed after restart", {31'b0, mopen_o}, 32'd0);

        // R2 key again keeps open, R3 wrong key closes at once
        wr(12'h00C, 32'hC5AF_6927);
        wr(12'h00C, 32'hC5AF_6927);
        check("R2 rekey stays open", {31'b0, mopen_o}, 32'd1);
        wr(12'h00C, 32'hC5AF_6926);
        check("R3 near-miss key closes", {31'b0, mopen_o}, 32'd0);

        // R6 / R7 global lock
        wr(12'h008, 32'h0000_0001);
        rd_check("R6 glock set", 12'h010, 32'hC000_0001);
        wr(12'h400, 32'h0);
        rd_check("R7 immutable blocked", 12'h400, 32'hA5A5_A5A5);
        wr(12'h100, 32'h5A00_00AA);
        rd_check("R7 keyed blocked", 12'h100, 32'h0000_00FF);
        wr(12'h00C, 32'hC5AF_6927);
        rd_check("R7 unlock flag under glock", 12'h010, 32'hC000_0003);
        wr(12'h800, 32'h0);
        rd_check("R7 mutable blocked", 12'h800, 32'hDEAD_BEEF);
        wr(12'h008, 32'h0);
        check("R6 glock sticky", {31'b0, glock_o}, 32'd1);

        // R11 reset clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_check("R11 status after reset", 12'h010, 32'hC000_0000);
        rd_check("R11 mutable after reset", 12'h800, 32'h0);
        rd_check("R11 immutable after reset", 12'h400, 32'h0);
        rd_check("R11 keyed after reset", 12'h100, 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule